// File: doc/BRIEF.md
# RV32 Integer Execute ALU

This block is the integer arithmetic unit of an RV32I execute stage. It takes a 4-bit function select and two 32-bit operands. It returns one 32-bit result in the same cycle, because there is no register anywhere in the path. The decode stage picks the function, and the result goes straight to the writeback or address path.

The unit covers several groups of functions:
- modulo add and subtract;
- the three bitwise operations;
- signed and unsigned set-less-than;
- three barrel shifts that use only the low five bits of the second operand;
- two pass-through functions, one for each operand, used for immediate loads and link values;
- an equality test, for branch resolution.

The three function codes left unassigned drive a zero result.

Top module: `rv_alu`

## Requirements
- R1: Function code 0 (add) outputs (a + b) mod 2^32.
- R2: Function code 1 (subtract) outputs (a - b) mod 2^32.
- R3: Function codes 2, 3 and 4 output the bitwise AND, OR and XOR of the operands, in that order.
- R4: Function code 5 outputs 1 when a < b as two's-complement values, else 0; bits 31:1 are always zero.
- R5: Function code 6 outputs 1 when a < b as unsigned values, else 0.
- R6: Function code 7 shifts a left by b[4:0] and fills with zeros; b[31:5] has no effect.
- R7: Function code 9 shifts a right by b[4:0] and fills with zeros; b[31:5] has no effect.
- R8: Function code 8 shifts a right by b[4:0] and fills with copies of a[31]; b[31:5] has no effect.
- R9: Function code 10 outputs a unchanged, and function code 11 outputs b unchanged.
- R10: Function code 12 outputs 1 when a equals b, else 0.
- R11: Function codes 13, 14 and 15 output zero for any operands.
- R12: The result depends only on the present inputs: it settles within the same clock cycle, with no clock or reset involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Function select (encoding given in R1 to R11) |
| a_i | input | 32 | First operand; the shifted value for shifts |
| b_i | input | 32 | Second operand; its low five bits give the shift amount |
| res_o | output | 32 | Function result |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the ports. The bench drives the select and the operands just after a rising clock edge. It samples the result 2 ns later, well before the next edge. A correct answer at that point shows that the path contains no latch or pipeline stage. The reference model and the comparison run on the sampled value only, so no result depends on the order of processes at an edge.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;
  localparam int unsigned FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_ADD   = 4'd0,
    FN_SUB   = 4'd1,
    FN_AND   = 4'd2,
    FN_OR    = 4'd3,
    FN_XOR   = 4'd4,
    FN_SLT   = 4'd5,
    FN_SLTU  = 4'd6,
    FN_SLL   = 4'd7,
    FN_SRA   = 4'd8,
    FN_SRL   = 4'd9,
    FN_CPY_A = 4'd10,
    FN_CPY_B = 4'd11,
    FN_SEQ   = 4'd12
  } alu_fn_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_fn_e;
endpackage

// File: rtl/rv_alu_addsub.sv
module rv_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         lt_o,
  output logic         ltu_o,
  output logic         eq_o
);
  localparam int unsigned EW = W + 1;

  logic [EW-1:0] ext;
  logic [W-1:0]  b_inv;

  assign b_inv = sub_i ? ~b_i : b_i;
  assign ext   = {1'b0, a_i} + {1'b0, b_inv} + EW'(sub_i);
  assign sum_o = ext[W-1:0];

  // compares are valid only while sub_i is set; carry out of a + ~b + 1 means a >= b
  assign ltu_o = ~ext[W];
  assign lt_o  = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : ext[W-1];
  assign eq_o  = (a_i == b_i);
endmodule

// File: rtl/rv_alu_logic.sv
module rv_alu_logic
  import rv_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/rv_alu_shift.sv
module rv_alu_shift #(
  parameter int unsigned W    = 32,
  parameter int unsigned SH_W = $clog2(W)
) (
  input  logic [W-1:0]    data_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [W-1:0]    data_o
);
  logic          fill;
  logic [W-1:0]  src;
  logic [W-1:0]  stage [SH_W+1];

  assign fill = arith_i & ~left_i & data_i[W-1];

  // left shift = bit-reverse, shift right, bit-reverse
  for (genvar k = 0; k < W; k++) begin : g_rev_in
    assign src[k] = left_i ? data_i[W-1-k] : data_i[k];
  end

  assign stage[0] = src;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned DIST = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{DIST{fill}}, stage[s][W-1:DIST]} : stage[s];
  end

  for (genvar k = 0; k < W; k++) begin : g_rev_out
    assign data_o[k] = left_i ? stage[SH_W][W-1-k] : stage[SH_W][k];
  end
endmodule

// File: rtl/rv_alu.sv
module rv_alu
  import rv_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [FN_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    res_o
);
  localparam int unsigned SH_W = $clog2(W);

  alu_fn_e   fn;
  logic      use_sub;
  logic      lt, ltu, eq;
  logic      shl, sha;
  logic_fn_e lg_sel;
  logic [W-1:0] sum, lg_res, sh_res;

  assign fn      = alu_fn_e'(op_i);
  assign use_sub = (fn == FN_SUB) | (fn == FN_SLT) | (fn == FN_SLTU);
  assign shl     = (fn == FN_SLL);
  assign sha     = (fn == FN_SRA);

  always_comb begin
    unique case (fn)
      FN_OR:   lg_sel = LG_OR;
      FN_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  rv_alu_addsub #(.W(W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (use_sub),
    .sum_o (sum),
    .lt_o  (lt),
    .ltu_o (ltu),
    .eq_o  (eq)
  );

  rv_alu_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (lg_sel),
    .res_o (lg_res)
  );

  rv_alu_shift #(.W(W), .SH_W(SH_W)) u_shift (
    .data_i  (a_i),
    .amt_i   (b_i[SH_W-1:0]),
    .left_i  (shl),
    .arith_i (sha),
    .data_o  (sh_res)
  );

  always_comb begin
    case (fn)
      FN_ADD, FN_SUB:         res_o = sum;
      FN_AND, FN_OR, FN_XOR:  res_o = lg_res;
      FN_SLT:                 res_o = W'(lt);
      FN_SLTU:                res_o = W'(ltu);
      FN_SLL, FN_SRA, FN_SRL: res_o = sh_res;
      FN_CPY_A:               res_o = a_i;
      FN_CPY_B:               res_o = b_i;
      FN_SEQ:                 res_o = W'(eq);
      default:                res_o = '0;
    endcase
  end
endmodule

// File: rtl/rv_alu_chk.sv
module rv_alu_chk #(
  parameter int unsigned W = 32
) (
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o
);
  always_comb begin
    // R11
    undef_zero_chk: assert (op_i < 4'd13 || res_o == '0);
    // R4 R5 R10
    cmp_bit_chk: assert (!(op_i == 4'd5 || op_i == 4'd6 || op_i == 4'd12) || res_o[W-1:1] == '0);
    // R9
    cpy_a_chk: assert (op_i != 4'd10 || res_o == a_i);
    // R9
    cpy_b_chk: assert (op_i != 4'd11 || res_o == b_i);
    // R8
    sra_sign_chk: assert (op_i != 4'd8 || res_o[W-1] == a_i[W-1]);
    // R6
    sll_zero_lsb_chk: assert (op_i != 4'd7 || b_i[4:0] == 5'd0 || res_o[0] == 1'b0);
    // R1
    add_ident_chk: assert (op_i != 4'd0 || b_i != '0 || res_o == a_i);
    // R10
    seq_self_chk: assert (op_i != 4'd12 || a_i != b_i || res_o == W'(1));
  end
endmodule

bind rv_alu rv_alu_chk #(.W(W)) u_chk (
  .op_i  (op_i),
  .a_i   (a_i),
  .b_i   (b_i),
  .res_o (res_o)
);

// File: tb/rv_alu_tb.sv
`timescale 1ns/1ps
module rv_alu_tb;
  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [31:0] a, b, res;
  int          checks = 0;
  int          fails  = 0;

  always #4 clk = ~clk;

  rv_alu u_dut (.op_i(op), .a_i(a), .b_i(b), .res_o(res));

  function automatic logic [31:0] model_fn(logic [3:0] f, logic [31:0] x, logic [31:0] y);
    case (f)
      4'd0:  return x + y;
      4'd1:  return x - y;
      4'd2:  return x & y;
      4'd3:  return x | y;
      4'd4:  return x ^ y;
      4'd5:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd6:  return (x < y) ? 32'd1 : 32'd0;
      4'd7:  return x << y[4:0];
      4'd8:  return 32'($signed(x) >>> y[4:0]);
      4'd9:  return x >> y[4:0];
      4'd10: return x;
      4'd11: return y;
      4'd12: return (x == y) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] f, input logic [31:0] x, input logic [31:0] y, input string tag);
    @(posedge clk);
    #1;
    op = f; a = x; b = y;
    #2;
    checks++;
    if (res !== model_fn(f, x, y)) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, f, x, y, res, model_fn(f, x, y));
    end
  endtask

  task automatic t_idle;
    apply(4'd0, 32'd0, 32'd0, "R1");
  endtask

  task automatic t_arith;
    apply(4'd0, 32'hFFFF_FFFF, 32'd1, "R1");
    apply(4'd0, 32'h7FFF_FFFF, 32'd1, "R1");
    apply(4'd1, 32'd0, 32'd1, "R2");
    apply(4'd1, 32'h8000_0000, 32'd1, "R2");
    for (int i = 0; i < 40; i++) begin
      apply(4'd0, $urandom, $urandom, "R1");
      apply(4'd1, $urandom, $urandom, "R2");
    end
  endtask

  task automatic t_bitwise;
    for (int i = 0; i < 30; i++)
      for (int f = 2; f <= 4; f++) apply(4'(f), $urandom, $urandom, "R3");
  endtask

  task automatic t_compare;
    apply(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
    apply(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, "R4");
    apply(4'd5, 32'hFFFF_FFFF, 32'd0, "R4");
    apply(4'd5, 32'd5, 32'd5, "R4");
    apply(4'd6, 32'hFFFF_FFFF, 32'd0, "R5");
    apply(4'd6, 32'd0, 32'hFFFF_FFFF, "R5");
    apply(4'd6, 32'd9, 32'd9, "R5");
    for (int i = 0; i < 40; i++) begin
      apply(4'd5, $urandom, $urandom, "R4");
      apply(4'd6, $urandom, $urandom, "R5");
    end
  endtask

  task automatic t_shift;
    for (int s = 0; s < 32; s++) begin
      apply(4'd7, 32'h8000_0001, 32'(s) | 32'hFFFF_FFE0, "R6");
      apply(4'd9, 32'h8000_0001, 32'(s) | 32'h0001_2340, "R7");
      apply(4'd8, 32'h8000_0001, 32'(s) | 32'hA5A5_A5A0, "R8");
      apply(4'd8, 32'h4000_0000, 32'(s), "R8");
    end
    apply(4'd7, 32'h0000_00FF, 32'd32, "R6");
    apply(4'd9, 32'hF000_0000, 32'd33, "R7");
    apply(4'd8, 32'hF000_0000, 32'd63, "R8");
    for (int i = 0; i < 30; i++) begin
      apply(4'd7, $urandom, $urandom, "R6");
      apply(4'd9, $urandom, $urandom, "R7");
      apply(4'd8, $urandom, $urandom, "R8");
    end
  endtask

  task automatic t_copy_eq;
    apply(4'd10, 32'hDEAD_BEEF, 32'h1234_5678, "R9");
    apply(4'd11, 32'hDEAD_BEEF, 32'h1234_5678, "R9");
    apply(4'd12, 32'hCAFE_F00D, 32'hCAFE_F00D, "R10");
    apply(4'd12, 32'hCAFE_F00D, 32'hCAFE_F00C, "R10");
    apply(4'd12, 32'd0, 32'd0, "R10");
    for (int i = 0; i < 20; i++) begin
      apply(4'd10, $urandom, $urandom, "R9");
      apply(4'd11, $urandom, $urandom, "R9");
      apply(4'd12, $urandom, $urandom, "R10");
    end
  endtask

  task automatic t_undef;
    for (int f = 13; f <= 15; f++) begin
      apply(4'(f), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11");
      apply(4'(f), $urandom, $urandom, "R11");
    end
  endtask

  // R12: inputs change after a rising edge and are sampled before the next one
  task automatic t_same_cycle;
    for (int f = 0; f < 16; f++) apply(4'(f), 32'h8765_4321, 32'h0000_0013, "R12");
  endtask

  initial begin
    op = 4'd0; a = '0; b = '0;
    t_idle();
    t_arith();
    t_bitwise();
    t_compare();
    t_shift();
    t_copy_eq();
    t_undef();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule